// File: doc/BRIEF.md
# BCH Correction Applier for a 512-Byte Sector

This block takes the result that a BCH decoder reports for one 512-byte sector and applies the bit corrections it names to a copy of that sector. The copy sits in an internal byte-wide RAM. Software or an upstream engine fills the RAM through a byte port. It then hands over the decoder result through a valid/ready handshake and reads the repaired sector back through the same byte port once `done` pulses.

The decoder result has five 32-bit words. The status word carries three fields: an error-found flag, an uncorrectable flag and an error count. The four position words each hold two 13-bit bit positions. The block unpacks the positions and walks through the first `count` of them in index order. It drops any position that points past the data area, into the parity bytes. Each remaining position is applied as a read-modify-write on the RAM that inverts a single bit. At most eight corrections per sector are possible, and the same result format covers both the 4-error and the 8-error decoder modes.

Top module: `bch_fix_apply`

## Requirements
- R1: After reset, `busy`, `done` and `err` are low and `res_ready` is high.
- R2: The status word carries the uncorrectable flag at bit 0, the error-found flag at bit 1 and the error count at bits 7:4. When the error-found flag is 0, the block finishes without error and leaves the buffer unchanged, whatever the other fields hold.
- R3: When the error-found flag is 1 and the uncorrectable flag is 1, the block finishes with `err` high and leaves the buffer unchanged.
- R4: `res_pos` holds four words, with word k (k = 1..4) at bits [32k-1:32k-32]. Word k carries position entry 2k-1 at bits 12:0 and entry 2k at bits 28:16. The remaining bits of each word are ignored.
- R5: Only the first `count` entries are applied, in increasing index order, and later entries have no effect. A count of zero with error-found set finishes without error and makes no change.
- R6: A position of 4096 (512 x 8) or more is skipped and changes no byte. Position 4095 is applied.
- R7: Applying position p inverts bit (p mod 8) of byte (p / 8). Applying the same position twice restores the byte.
- R8: `done` is a one-cycle pulse, and `err` is valid only while `done` is high. Counting the clock edge that accepts the result as edge 0, `done` rises at edge 1 for the early exits (R2, R3, R10). Otherwise it rises at edge 2 + 2*A + S, where A is the number of applied entries and S the number of skipped entries.
- R9: `busy` is high from the edge after acceptance until `done`, and `res_ready` is low while `busy` is high. While `busy` is high, buffer-port writes are ignored and buffer-port reads return no `buf_rvalid`.
- R10: When the error-found flag is 1, the uncorrectable flag is 0 and the count exceeds 8, the block treats the sector as uncorrectable: `err` goes high and the buffer is unchanged.
- R11: A buffer-port write presented in the same cycle that a result is accepted is stored, and the corrections that follow are applied on top of it.
- R12: While idle, a buffer-port read of byte a returns that byte on `buf_rdata` with `buf_rvalid` high one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | Decoder result valid |
| res_ready | output | 1 | Result accepted when high together with `res_valid` |
| res_status | input | 32 | Status word: uncorrectable, error-found, count |
| res_pos | input | 128 | Four packed position words, word 1 in the low bits |
| buf_addr | input | 9 | Byte address of the sector buffer |
| buf_wdata | input | 8 | Byte to write |
| buf_wen | input | 1 | Write strobe for the buffer port |
| buf_ren | input | 1 | Read strobe for the buffer port |
| buf_rdata | output | 8 | Read byte, valid with `buf_rvalid` |
| buf_rvalid | output | 1 | Read data valid, one cycle after `buf_ren` |
| busy | output | 1 | Corrections in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Uncorrectable sector, valid with `done` |

## Verification
A buffer-port write and the acceptance of a decoder result can fall in the same clock cycle. The bench provokes this by raising `res_valid` and `buf_wen` together, with the write aimed at a byte that one of the reported positions then flips. The scoreboard expects the written value with that one bit inverted, so both a dropped write and a correction applied to the old byte content are reported. A second collision comes from port writes and reads issued while corrections run. These are judged by reading the sector back and by the absence of `buf_rvalid`.

// File: rtl/bch_fix_pkg.sv
package bch_fix_pkg;

    // Sequencer states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_SEL   = 2'd2,
        ST_RMW   = 2'd3
    } seq_state_e;

    // Field positions inside the status word; a decoder upstream fills them
    localparam int UNC_BIT   = 0;
    localparam int FOUND_BIT = 1;
    localparam int CNT_LSB   = 4;
    localparam int CNT_W     = 4;

    // Low bit of the upper position inside each packed position word
    localparam int HI_LSB    = 16;

endpackage

// File: rtl/fix_ram.sv
module fix_ram #(
    parameter int DEPTH  = 512,
    parameter int DATA_W = 8,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    // Single port, read-before-write, one cycle read latency
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                mem[addr] <= wdata;
            end
            rdata_q <= mem[addr];
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/pos_unpack.sv
module pos_unpack
    import bch_fix_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int POS_W   = 13,
    parameter int MAX_ERR = 8,
    localparam int PAIRS  = MAX_ERR / 2
) (
    input  logic [PAIRS-1:0][WORD_W-1:0]  words,
    output logic [MAX_ERR-1:0][POS_W-1:0] pos_list
);

    logic [PAIRS-1:0] unused_pair;

    // Each word yields an even-index entry in its low half and the next entry above
    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        assign pos_list[2*p]   = words[p][POS_W-1:0];
        assign pos_list[2*p+1] = words[p][HI_LSB +: POS_W];
        assign unused_pair[p]  = ^{words[p][WORD_W-1:HI_LSB+POS_W],
                                   words[p][HI_LSB-1:POS_W]};
    end

endmodule

// File: rtl/fix_seq.sv
module fix_seq
    import bch_fix_pkg::*;
#(
    parameter int WORD_W       = 32,
    parameter int POS_W        = 13,
    parameter int MAX_ERR      = 8,
    parameter int SECTOR_BYTES = 512,
    localparam int PAIRS       = MAX_ERR / 2,
    localparam int ADDR_W      = $clog2(SECTOR_BYTES),
    localparam int SECTOR_BITS = SECTOR_BYTES * 8,
    localparam int IDX_W       = $clog2(MAX_ERR + 1),
    localparam int PIDX_W      = $clog2(MAX_ERR)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          res_valid,
    output logic                          res_ready,
    input  logic [WORD_W-1:0]             res_status,
    input  logic [PAIRS-1:0][WORD_W-1:0]  res_words,
    output logic [PAIRS-1:0][WORD_W-1:0]  held_words,
    input  logic [MAX_ERR-1:0][POS_W-1:0] pos_list,
    output logic                          ram_en,
    output logic                          ram_we,
    output logic [ADDR_W-1:0]             ram_addr,
    output logic [7:0]                    ram_wdata,
    input  logic [7:0]                    ram_rdata,
    output logic                          busy,
    output logic                          done,
    output logic                          err
);

    typedef struct packed {
        seq_state_e                      state;
        logic [IDX_W-1:0]                idx;
        logic [CNT_W-1:0]                cnt;
        logic                            found;
        logic                            unc;
        logic [PAIRS-1:0][WORD_W-1:0]    words;
        logic                            done;
        logic                            err;
    } seq_t;

    seq_t q, d;
    logic [POS_W-1:0] cur_pos;
    logic             unused_status;

    assign unused_status = ^{res_status[WORD_W-1:CNT_LSB+CNT_W],
                             res_status[CNT_LSB-1:FOUND_BIT+1]};

    assign cur_pos = pos_list[q.idx[PIDX_W-1:0]];

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        d.err     = 1'b0;
        ram_en    = 1'b0;
        ram_we    = 1'b0;
        ram_addr  = cur_pos[3 +: ADDR_W];
        ram_wdata = ram_rdata ^ (8'(1) << cur_pos[2:0]);

        case (q.state)
            ST_IDLE: begin
                if (res_valid) begin
                    d.state = ST_CHECK;
                    d.words = res_words;
                    d.found = res_status[FOUND_BIT];
                    d.unc   = res_status[UNC_BIT];
                    d.cnt   = res_status[CNT_LSB +: CNT_W];
                    d.idx   = '0;
                end
            end
            ST_CHECK: begin
                if (!q.found) begin
                    d.state = ST_IDLE;
                    d.done  = 1'b1;
                end else if (q.unc || (32'(q.cnt) > MAX_ERR)) begin
                    d.state = ST_IDLE;
                    d.done  = 1'b1;
                    d.err   = 1'b1;
                end else begin
                    d.state = ST_SEL;
                end
            end
            ST_SEL: begin
                if (32'(q.idx) == 32'(q.cnt)) begin
                    d.state = ST_IDLE;
                    d.done  = 1'b1;
                end else if (32'(cur_pos) >= SECTOR_BITS) begin
                    // Entry points into parity bytes: skip it
                    d.idx = q.idx + IDX_W'(1);
                end else begin
                    ram_en  = 1'b1;
                    d.state = ST_RMW;
                end
            end
            ST_RMW: begin
                ram_en  = 1'b1;
                ram_we  = 1'b1;
                d.idx   = q.idx + IDX_W'(1);
                d.state = ST_SEL;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign res_ready  = (q.state == ST_IDLE);
    assign busy       = (q.state != ST_IDLE);
    assign done       = q.done;
    assign err        = q.err;
    assign held_words = q.words;

    // R2
    found_clear_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_CHECK && !q.found) |=> (done && !err));

    // R3
    unc_flag_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_CHECK && q.found && q.unc) |=> (done && err));

    // R7
    rmw_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> ($past(ram_en && !ram_we) && ram_addr == $past(ram_addr)));

    // R9
    busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R8
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

endmodule

// File: rtl/bch_fix_apply.sv
module bch_fix_apply
    import bch_fix_pkg::*;
#(
    parameter int WORD_W       = 32,
    parameter int POS_W        = 13,
    parameter int MAX_ERR      = 8,
    parameter int SECTOR_BYTES = 512,
    localparam int PAIRS       = MAX_ERR / 2,
    localparam int ADDR_W      = $clog2(SECTOR_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    res_valid,
    output logic                    res_ready,
    input  logic [WORD_W-1:0]       res_status,
    input  logic [PAIRS*WORD_W-1:0] res_pos,
    input  logic [ADDR_W-1:0]       buf_addr,
    input  logic [7:0]              buf_wdata,
    input  logic                    buf_wen,
    input  logic                    buf_ren,
    output logic [7:0]              buf_rdata,
    output logic                    buf_rvalid,
    output logic                    busy,
    output logic                    done,
    output logic                    err
);

    logic [PAIRS-1:0][WORD_W-1:0]  res_words;
    logic [PAIRS-1:0][WORD_W-1:0]  held_words;
    logic [MAX_ERR-1:0][POS_W-1:0] pos_list;

    logic              seq_en, seq_we;
    logic [ADDR_W-1:0] seq_addr;
    logic [7:0]        seq_wdata;
    logic              ram_en, ram_we;
    logic [ADDR_W-1:0] ram_addr;
    logic [7:0]        ram_wdata, ram_rdata;
    logic              rvalid_d, rvalid_q;

    assign res_words = res_pos;

    pos_unpack #(
        .WORD_W (WORD_W),
        .POS_W  (POS_W),
        .MAX_ERR(MAX_ERR)
    ) u_unpack (
        .words   (held_words),
        .pos_list(pos_list)
    );

    fix_seq #(
        .WORD_W      (WORD_W),
        .POS_W       (POS_W),
        .MAX_ERR     (MAX_ERR),
        .SECTOR_BYTES(SECTOR_BYTES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .res_valid (res_valid),
        .res_ready (res_ready),
        .res_status(res_status),
        .res_words (res_words),
        .held_words(held_words),
        .pos_list  (pos_list),
        .ram_en    (seq_en),
        .ram_we    (seq_we),
        .ram_addr  (seq_addr),
        .ram_wdata (seq_wdata),
        .ram_rdata (ram_rdata),
        .busy      (busy),
        .done      (done),
        .err       (err)
    );

    // The sequencer owns the RAM while busy; the byte port otherwise
    always_comb begin
        if (busy) begin
            ram_en    = seq_en;
            ram_we    = seq_we;
            ram_addr  = seq_addr;
            ram_wdata = seq_wdata;
        end else begin
            ram_en    = buf_wen | buf_ren;
            ram_we    = buf_wen;
            ram_addr  = buf_addr;
            ram_wdata = buf_wdata;
        end
        rvalid_d = buf_ren & ~busy;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= rvalid_d;
        end
    end

    fix_ram #(
        .DEPTH (SECTOR_BYTES),
        .DATA_W(8)
    ) u_ram (
        .clk  (clk),
        .en   (ram_en),
        .we   (ram_we),
        .addr (ram_addr),
        .wdata(ram_wdata),
        .rdata(ram_rdata)
    );

    assign buf_rdata  = ram_rdata;
    assign buf_rvalid = rvalid_q;

    // R9
    no_port_rvalid_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && buf_ren) |=> !buf_rvalid);

endmodule

// File: tb/bch_fix_apply_tb.sv
module bch_fix_apply_tb;

    localparam int SB = 512;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         res_valid = 1'b0;
    logic         res_ready;
    logic [31:0]  res_status = '0;
    logic [127:0] res_pos = '0;
    logic [8:0]   buf_addr = '0;
    logic [7:0]   buf_wdata = '0;
    logic         buf_wen = 1'b0;
    logic         buf_ren = 1'b0;
    logic [7:0]   buf_rdata;
    logic         buf_rvalid;
    logic         busy, done, err;

    always #2 clk = ~clk;   // 250 MHz

    bch_fix_apply u_dut (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ready(res_ready),
        .res_status(res_status), .res_pos(res_pos), .buf_addr(buf_addr),
        .buf_wdata(buf_wdata), .buf_wen(buf_wen), .buf_ren(buf_ren),
        .buf_rdata(buf_rdata), .buf_rvalid(buf_rvalid), .busy(busy),
        .done(done), .err(err)
    );

    typedef struct {
        bit    err;
        int    lat;
        string tag;
    } exp_t;

    exp_t       q_exp[$];
    logic [7:0] model [SB];
    int         checks = 0;
    int         fails = 0;
    int         cyc = 0;
    int         accept_cyc = 0;
    bit         finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // Monitor: pops an expected completion for every done pulse
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (q_exp.size() == 0) begin
                check(1'b0, "R8 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = q_exp.pop_front();
                check(err == e.err, {e.tag, " err flag"}, int'(err), int'(e.err));
                check((cyc - accept_cyc) == e.lat, "R8 done latency",
                      cyc - accept_cyc, e.lat);
            end
        end
    end

    task automatic wr(input int a, input logic [7:0] v);
        buf_addr  = 9'(a);
        buf_wdata = v;
        buf_wen   = 1'b1;
        @(negedge clk);
        buf_wen   = 1'b0;
    endtask

    task automatic rd(input int a, output logic [7:0] v, output bit vld);
        buf_addr = 9'(a);
        buf_ren  = 1'b1;
        @(negedge clk);
        buf_ren  = 1'b0;
        v   = buf_rdata;
        vld = buf_rvalid;
    endtask

    task automatic load(input int seed);
        for (int i = 0; i < SB; i++) begin
            logic [7:0] v;
            v = 8'(i * 7 + seed * 13 + 1);
            model[i] = v;
            wr(i, v);
        end
    endtask

    task automatic check_buffer(input string tag);
        int         bad = 0;
        int         first = -1;
        int         act = 0;
        bit         novld = 1'b0;
        for (int i = 0; i < SB; i++) begin
            logic [7:0] v;
            bit         vld;
            rd(i, v, vld);
            if (!vld) novld = 1'b1;
            if (v !== model[i]) begin
                if (first < 0) begin
                    first = i;
                    act   = int'(v);
                end
                bad++;
            end
        end
        check(!novld, "R12 read valid while idle", 0, 1);
        if (first < 0) check(1'b1, tag, 0, 0);
        else check(1'b0, tag, act, int'(model[first]));
    endtask

    function automatic logic [31:0] mk_status(bit found, bit unc, int cnt);
        return (32'(cnt) << 4) | (32'(found) << 1) | 32'(unc) | 32'h0000_FF0C;
    endfunction

    // Expected behaviour from the requirements; also returns done latency
    task automatic model_apply(input logic [31:0] st, input int p[8],
                               output bit e_err, output int e_lat);
        bit found = st[1];
        bit unc   = st[0];
        int cnt   = int'(st[7:4]);
        e_err = 1'b0;
        e_lat = 1;
        if (found) begin
            if (unc || cnt > 8) begin
                e_err = 1'b1;
            end else begin
                e_lat = 2;
                for (int i = 0; i < cnt; i++) begin
                    if (p[i] < SB * 8) begin
                        model[p[i] / 8] = model[p[i] / 8] ^ (8'(1) << (p[i] % 8));
                        e_lat += 2;
                    end else begin
                        e_lat += 1;
                    end
                end
            end
        end
    endtask

    // Driver: pushes the expected completion and presents the result
    task automatic start_res(input logic [31:0] st, input int p[8], input string tag,
                             input bit with_wr, input int wa, input logic [7:0] wd);
        exp_t e;
        bit   e_err;
        int   e_lat;
        if (with_wr) model[wa] = wd;
        model_apply(st, p, e_err, e_lat);
        e.err = e_err;
        e.lat = e_lat;
        e.tag = tag;
        q_exp.push_back(e);
        check(res_ready === 1'b1, "R9 ready while idle", int'(res_ready), 1);
        res_status = st;
        for (int k = 0; k < 4; k++) begin
            res_pos[32*k +: 32] = {3'b101, 13'(p[2*k+1]), 3'b110, 13'(p[2*k])};
        end
        res_valid = 1'b1;
        if (with_wr) begin
            buf_addr  = 9'(wa);
            buf_wdata = wd;
            buf_wen   = 1'b1;
        end
        @(negedge clk);
        res_valid  = 1'b0;
        buf_wen    = 1'b0;
        accept_cyc = cyc;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run(input logic [31:0] st, input int p[8], input string tag);
        start_res(st, p, tag, 1'b0, 0, 8'h00);
        wait_done();
        check_buffer({tag, " buffer content"});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        report();
    end

    initial begin
        int         pa[8];
        logic [7:0] v;
        bit         vld;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(busy === 1'b0, "R1 busy after reset", int'(busy), 0);
        check(done === 1'b0, "R1 done after reset", int'(done), 0);
        check(err === 1'b0, "R1 err after reset", int'(err), 0);
        check(res_ready === 1'b1, "R1 ready after reset", int'(res_ready), 1);

        // R12 plain write then read
        wr(33, 8'hA7);
        rd(33, v, vld);
        check(vld && v == 8'hA7, "R12 readback", int'(v), 8'hA7);

        // R2 error-found clear: nothing applied even with uncorrectable set
        load(1);
        pa = '{5, 6, 7, 8, 9, 10, 11, 12};
        run(mk_status(1'b0, 1'b1, 3), pa, "R2");

        // R3 uncorrectable
        pa = '{8, 9, 10, 11, 12, 13, 14, 15};
        run(mk_status(1'b1, 1'b1, 2), pa, "R3");

        // R10 count above eight
        run(mk_status(1'b1, 1'b0, 9), pa, "R10");

        // R4 R7 all eight entries, both halves of every word
        load(2);
        pa = '{0, 4095, 100, 1001, 2050, 3333, 17, 777};
        run(mk_status(1'b1, 1'b0, 8), pa, "R4 R7 full unpack");

        // R6 out-of-range positions skipped, 4095 applied
        pa = '{4096, 8191, 4095, 12, 0, 0, 0, 0};
        run(mk_status(1'b1, 1'b0, 4), pa, "R6 skip parity");

        // R5 only the first count entries
        pa = '{40, 41, 50, 51, 60, 61, 70, 71};
        run(mk_status(1'b1, 1'b0, 2), pa, "R5 count limit");

        // R5 zero count with error-found
        run(mk_status(1'b1, 1'b0, 0), pa, "R5 zero count");

        // R7 same position twice restores the byte
        pa = '{300, 300, 1, 2, 3, 4, 5, 6};
        run(mk_status(1'b1, 1'b0, 2), pa, "R7 double flip");

        // R9 port blocked while corrections run
        load(3);
        pa = '{0, 4095, 100, 1001, 2050, 3333, 17, 777};
        start_res(mk_status(1'b1, 1'b0, 8), pa, "R9 busy run", 1'b0, 0, 8'h00);
        check(busy === 1'b1, "R9 busy after accept", int'(busy), 1);
        check(res_ready === 1'b0, "R9 ready low while busy", int'(res_ready), 0);
        wr(10, 8'hEE);
        rd(10, v, vld);
        check(vld === 1'b0, "R9 no rvalid while busy", int'(vld), 0);
        wait_done();
        check_buffer("R9 write during busy ignored");

        // R11 port write in the acceptance cycle, flipped afterwards
        pa = '{163, 4100, 0, 0, 0, 0, 0, 0};
        start_res(mk_status(1'b1, 1'b0, 2), pa, "R11 same cycle", 1'b1, 20, 8'h55);
        wait_done();
        check_buffer("R11 write plus flip");
        rd(20, v, vld);
        check(v == 8'h5D, "R11 byte 20", int'(v), 8'h5D);

        check(q_exp.size() == 0, "R8 missing done", q_exp.size(), 0);
        report();
    end

endmodule